// File: doc/BRIEF.md
# Dynamic Warp Former

After a divergent branch, partial warps sit in a waiting pool, each holding only some of its lanes active. This block takes those partial warps one per clock as (warp ID, program counter, lane mask) and packs threads that sit at the same program counter into fuller warps, so that more SIMD lanes do useful work on each issue. A thread keeps its home lane: the thread in lane `l` of warp `w` has thread ID `w*LANES + l` and can only appear in lane `l` of a formed warp. Two partial warps combine only when their lane masks are disjoint.

Pending formed warps are held in a small age-ordered array that is searched by program counter. A formed warp is issued when all of its lanes are filled, when the array is full and a new entry must be made, or when a flush request drains the array. Each issued warp carries its program counter, a per-lane thread-ID vector, its lane mask and a count of active lanes.

The controller has two states. ACCEPT takes arrivals. The transition ACCEPT to DRAIN is taken on a flush request while at least one entry is pending. DRAIN issues one pending entry per cycle, oldest first. The transition DRAIN to ACCEPT is taken in the cycle that issues the last pending entry.

Top module: `dwf_former`

## Requirements
- R1: After reset no warp is issued and no entry is pending, so a flush issued right after reset produces no output.
- R2: An arrival in ACCEPT whose mask has every lane set is issued unchanged one cycle later, with no other effect on the pending entries.
- R3: In every issued warp, lane `l` carries thread ID `w*LANES + l`, where `w` is the warp ID that supplied that lane. Lanes that are not active carry thread ID 0. Mask bit `l` stands for lane `l`.
- R4: An arrival merges into a pending entry only when the program counters are equal and the two lane masks share no set bit. Each merged lane keeps the warp ID of the arrival that supplied it.
- R5: When a merge fills every lane, the merged warp is issued one cycle after the arrival and its entry is freed.
- R6: An arrival whose program counter matches no pending entry, or whose mask overlaps every same-PC entry, opens a new entry as the youngest.
- R7: When several pending entries qualify for a merge, the oldest one is chosen.
- R8: A flush in ACCEPT with entries pending issues all of them oldest first, one per cycle, starting two cycles after the flush. Arrivals in the flush cycle and during draining are discarded.
- R9: When all entries are in use and an arrival cannot merge, the oldest entry is issued one cycle later and the arrival becomes the youngest entry.
- R10: The active-lane count output equals the number of set bits in the issued mask.
- R11: An arrival with an all-zero mask is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A partial warp is presented this cycle |
| in_wid | input | WID_W | Warp ID of the arrival |
| in_pc | input | PC_W | Program counter of the arrival |
| in_mask | input | LANES | Active lanes of the arrival, bit l is lane l |
| flush | input | 1 | Drain every pending entry |
| out_valid | output | 1 | A formed warp is issued this cycle |
| out_pc | output | PC_W | Program counter of the issued warp |
| out_mask | output | LANES | Active lanes of the issued warp |
| out_tids | output | LANES*(WID_W+log2 LANES) | Thread ID per lane, lane 0 in the low field |
| out_count | output | log2(LANES+1) | Number of active lanes |

## Verification
A full-mask arrival, a merge that fills every lane, and an eviction from a full array are each issued in the cycle after the arrival edge. A drain begins issuing two cycles after the flush edge and then issues one entry per cycle. The driver changes inputs on falling edges and pushes each expected warp into an ordered queue when it applies the stimulus. The monitor samples the outputs on every falling edge, so each issued warp is seen at the first falling edge after the rising edge that registered it. Any issue with no queued expectation, and any expectation still in the queue after a settle period, is reported.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_DRAIN  = 1'b1
    } dwf_state_e;
endpackage

// File: rtl/dwf_match.sv
// Associative search of pending entries: same PC and disjoint lane masks.
// The lowest index (oldest entry) wins.
module dwf_match #(
    parameter int SLOTS = 4,
    parameter int LANES = 4,
    parameter int PC_W  = 12
) (
    input  logic [SLOTS-1:0]       slot_used,
    input  logic [SLOTS*PC_W-1:0]  slot_pc_flat,
    input  logic [SLOTS*LANES-1:0] slot_mask_flat,
    input  logic [PC_W-1:0]        probe_pc,
    input  logic [LANES-1:0]       probe_mask,
    output logic                   hit,
    output logic [$clog2(SLOTS)-1:0] hit_idx
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS-1:0] cand;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
            assign cand[s] = slot_used[s]
                && (slot_pc_flat[s*PC_W +: PC_W] == probe_pc)
                && ((slot_mask_flat[s*LANES +: LANES] & probe_mask) == '0);
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (cand[s]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/dwf_pack.sv
// Builds the per-lane thread-ID vector and active-lane count of a warp.
module dwf_pack #(
    parameter int LANES = 4,
    parameter int WID_W = 4
) (
    input  logic [LANES-1:0]                         lane_mask,
    input  logic [LANES*WID_W-1:0]                   lane_wid,
    output logic [LANES*(WID_W+$clog2(LANES))-1:0]   lane_tid,
    output logic [$clog2(LANES+1)-1:0]               active_cnt
);
    localparam int LANE_W = $clog2(LANES);
    localparam int TID_W  = WID_W + LANE_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_tid[l*TID_W +: TID_W] = lane_mask[l]
                ? {lane_wid[l*WID_W +: WID_W], LANE_W'(l)}
                : '0;
        end
    endgenerate

    always_comb begin
        active_cnt = '0;
        for (int l = 0; l < LANES; l++) begin
            active_cnt = active_cnt + CNT_W'(lane_mask[l]);
        end
    end
endmodule

// File: rtl/dwf_former.sv
module dwf_former
    import dwf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SLOTS = 4,
    parameter int PC_W  = 12,
    parameter int WID_W = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [WID_W-1:0]                       in_wid,
    input  logic [PC_W-1:0]                        in_pc,
    input  logic [LANES-1:0]                       in_mask,
    input  logic                                   flush,
    output logic                                   out_valid,
    output logic [PC_W-1:0]                        out_pc,
    output logic [LANES-1:0]                       out_mask,
    output logic [LANES*(WID_W+$clog2(LANES))-1:0] out_tids,
    output logic [$clog2(LANES+1)-1:0]             out_count
);
    localparam int LANE_W = $clog2(LANES);
    localparam int TID_W  = WID_W + LANE_W;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int OCC_W  = $clog2(SLOTS + 1);

    dwf_state_e state_q, state_d;

    // Age-ordered pending entries: index 0 is the oldest.
    logic [PC_W-1:0]        pc_q   [SLOTS];
    logic [PC_W-1:0]        pc_d   [SLOTS];
    logic [LANES-1:0]       mask_q [SLOTS];
    logic [LANES-1:0]       mask_d [SLOTS];
    logic [LANES*WID_W-1:0] wid_q  [SLOTS];
    logic [LANES*WID_W-1:0] wid_d  [SLOTS];
    logic [OCC_W-1:0]       occ_q, occ_d;

    logic [SLOTS-1:0]       used;
    logic [SLOTS*PC_W-1:0]  pc_flat;
    logic [SLOTS*LANES-1:0] mask_flat;
    logic                   hit;
    logic [IDX_W-1:0]       hit_idx;

    logic                   emit;
    logic [PC_W-1:0]        e_pc;
    logic [LANES-1:0]       e_mask;
    logic [LANES*WID_W-1:0] e_wid;
    logic [LANES-1:0]       merged_mask;
    logic [LANES*WID_W-1:0] merged_wid;
    logic [LANES*WID_W-1:0] in_wid_rep;
    logic [LANES*TID_W-1:0] e_tids;
    logic [CNT_W-1:0]       e_cnt;

    assign in_wid_rep = {LANES{in_wid}};

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_flat
            assign used[s]                    = OCC_W'(s) < occ_q;
            assign pc_flat[s*PC_W +: PC_W]    = pc_q[s];
            assign mask_flat[s*LANES +: LANES] = mask_q[s];
        end
    endgenerate

    dwf_match #(.SLOTS(SLOTS), .LANES(LANES), .PC_W(PC_W)) match_i (
        .slot_used      (used),
        .slot_pc_flat   (pc_flat),
        .slot_mask_flat (mask_flat),
        .probe_pc       (in_pc),
        .probe_mask     (in_mask),
        .hit            (hit),
        .hit_idx        (hit_idx)
    );

    dwf_pack #(.LANES(LANES), .WID_W(WID_W)) pack_i (
        .lane_mask  (emit ? e_mask : '0),
        .lane_wid   (e_wid),
        .lane_tid   (e_tids),
        .active_cnt (e_cnt)
    );

    always_comb begin
        merged_mask = mask_q[hit_idx] | in_mask;
        for (int l = 0; l < LANES; l++) begin
            merged_wid[l*WID_W +: WID_W] = in_mask[l] ? in_wid
                                         : wid_q[hit_idx][l*WID_W +: WID_W];
        end
    end

    // Next-state, entry update and emission selection.
    always_comb begin
        state_d = state_q;
        occ_d   = occ_q;
        for (int s = 0; s < SLOTS; s++) begin
            pc_d[s]   = pc_q[s];
            mask_d[s] = mask_q[s];
            wid_d[s]  = wid_q[s];
        end
        emit   = 1'b0;
        e_pc   = in_pc;
        e_mask = in_mask;
        e_wid  = in_wid_rep;

        unique case (state_q)
            ST_ACCEPT: begin
                if (flush) begin
                    if (occ_q != '0) state_d = ST_DRAIN;
                end else if (in_valid && (in_mask != '0)) begin
                    if (in_mask == '1) begin
                        emit = 1'b1;
                    end else if (hit) begin
                        if (merged_mask == '1) begin
                            emit   = 1'b1;
                            e_mask = merged_mask;
                            e_wid  = merged_wid;
                            for (int s = 0; s < SLOTS - 1; s++) begin
                                if (s >= int'(hit_idx)) begin
                                    pc_d[s]   = pc_q[s+1];
                                    mask_d[s] = mask_q[s+1];
                                    wid_d[s]  = wid_q[s+1];
                                end
                            end
                            occ_d = occ_q - OCC_W'(1);
                        end else begin
                            mask_d[hit_idx] = merged_mask;
                            wid_d[hit_idx]  = merged_wid;
                        end
                    end else if (occ_q < OCC_W'(SLOTS)) begin
                        pc_d[IDX_W'(occ_q)]   = in_pc;
                        mask_d[IDX_W'(occ_q)] = in_mask;
                        wid_d[IDX_W'(occ_q)]  = in_wid_rep;
                        occ_d = occ_q + OCC_W'(1);
                    end else begin
                        emit   = 1'b1;
                        e_pc   = pc_q[0];
                        e_mask = mask_q[0];
                        e_wid  = wid_q[0];
                        for (int s = 0; s < SLOTS - 1; s++) begin
                            pc_d[s]   = pc_q[s+1];
                            mask_d[s] = mask_q[s+1];
                            wid_d[s]  = wid_q[s+1];
                        end
                        pc_d[SLOTS-1]   = in_pc;
                        mask_d[SLOTS-1] = in_mask;
                        wid_d[SLOTS-1]  = in_wid_rep;
                    end
                end
            end
            ST_DRAIN: begin
                if (occ_q != '0) begin
                    emit   = 1'b1;
                    e_pc   = pc_q[0];
                    e_mask = mask_q[0];
                    e_wid  = wid_q[0];
                    for (int s = 0; s < SLOTS - 1; s++) begin
                        pc_d[s]   = pc_q[s+1];
                        mask_d[s] = mask_q[s+1];
                        wid_d[s]  = wid_q[s+1];
                    end
                    occ_d = occ_q - OCC_W'(1);
                end
                if (occ_q <= OCC_W'(1)) state_d = ST_ACCEPT;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    // Entry storage and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q     <= '0;
            out_valid <= 1'b0;
            out_pc    <= '0;
            out_mask  <= '0;
            out_tids  <= '0;
            out_count <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                pc_q[s]   <= '0;
                mask_q[s] <= '0;
                wid_q[s]  <= '0;
            end
        end else begin
            occ_q     <= occ_d;
            out_valid <= emit;
            out_pc    <= emit ? e_pc : '0;
            out_mask  <= emit ? e_mask : '0;
            out_tids  <= e_tids;
            out_count <= e_cnt;
            for (int s = 0; s < SLOTS; s++) begin
                pc_q[s]   <= pc_d[s];
                mask_q[s] <= mask_d[s];
                wid_q[s]  <= wid_d[s];
            end
        end
    end

    // ---------------- assertions ----------------
    a_r2_full_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCEPT && !flush && in_valid && in_mask == '1)
        |=> (out_valid && out_mask == '1 && out_pc == $past(in_pc)));

    a_r4_merge_target_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCEPT && in_valid && hit)
        |-> ((mask_q[hit_idx] & in_mask) == '0 && pc_q[hit_idx] == in_pc
             && OCC_W'(hit_idx) < occ_q));

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_chk
            a_r5_pending_partial: assert property (@(posedge clk) disable iff (!rst_n)
                (OCC_W'(s) < occ_q) |-> (mask_q[s] != '1 && mask_q[s] != '0));
        end
    endgenerate

    a_r8_flush_enters_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCEPT && flush && occ_q != '0)
        |=> (state_q == ST_DRAIN && !out_valid));

    a_r8_drain_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> out_valid);

    a_r9_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(SLOTS));

    a_r10_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_count) == $countones(out_mask)));

    a_r11_zero_mask_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCEPT && !flush && in_valid && in_mask == '0)
        |=> (!out_valid && $stable(occ_q)));
endmodule

// File: tb/dwf_former_tb.sv
module dwf_former_tb_top;
    localparam int LANES = 4;
    localparam int WID_W = 4;
    localparam int PC_W  = 12;
    localparam int TID_W = 6;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [WID_W-1:0] in_wid = '0;
    logic [PC_W-1:0]  in_pc = '0;
    logic [LANES-1:0] in_mask = '0;
    logic flush = 1'b0;
    logic out_valid;
    logic [PC_W-1:0] out_pc;
    logic [LANES-1:0] out_mask;
    logic [LANES*TID_W-1:0] out_tids;
    logic [CNT_W-1:0] out_count;

    always #10 clk = ~clk;   // 50 MHz

    dwf_former #(.LANES(LANES), .SLOTS(4), .PC_W(PC_W), .WID_W(WID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wid(in_wid),
        .in_pc(in_pc), .in_mask(in_mask), .flush(flush),
        .out_valid(out_valid), .out_pc(out_pc), .out_mask(out_mask),
        .out_tids(out_tids), .out_count(out_count)
    );

    typedef struct {
        logic [PC_W-1:0]        pc;
        logic [LANES-1:0]       mask;
        logic [LANES*TID_W-1:0] tids;
        logic [CNT_W-1:0]       cnt;
        string                  tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected warp: per-lane warp IDs in 4-bit fields, lane 0 lowest.
    task automatic exp_push(input logic [PC_W-1:0] pc, input logic [LANES-1:0] mask,
                            input logic [15:0] wids, input string tag);
        exp_t e;
        e.pc = pc; e.mask = mask; e.tids = '0; e.cnt = '0; e.tag = tag;
        for (int l = 0; l < LANES; l++) begin
            if (mask[l]) begin
                e.tids[l*TID_W +: TID_W] = {wids[l*4 +: 4], 2'(l)};
                e.cnt = e.cnt + 3'd1;
            end
        end
        sb.push_back(e);
    endtask

    task automatic send(input int wid, input int pc, input logic [3:0] mask);
        in_valid = 1'b1; in_wid = WID_W'(wid); in_pc = PC_W'(pc); in_mask = mask;
        @(negedge clk);
        in_valid = 1'b0; in_mask = '0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic settle(input string tag);
        repeat (6) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected warps not issued (actual %0d pending, expected 0)",
                     tag, sb.size(), sb.size());
            sb.delete();
        end
    endtask

    // Monitor / scoreboard compare.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected warp: actual pc=%h mask=%b, expected none",
                         out_pc, out_mask);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_pc !== e.pc || out_mask !== e.mask || out_tids !== e.tids
                    || out_count !== e.cnt) begin
                    fails++;
                    $display("FAIL %s: actual pc=%h mask=%b tids=%h cnt=%0d, expected pc=%h mask=%b tids=%h cnt=%0d",
                             e.tag, out_pc, out_mask, out_tids, out_count,
                             e.pc, e.mask, e.tids, e.cnt);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual run unfinished, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1: quiet during reset
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual out_valid=%b, expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1: quiet after reset
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual out_valid=%b, expected 0", out_valid);
        end
        do_flush();               // R1: nothing pending
        settle("R1 empty after reset");

        // R2 / R3 / R10: full-mask arrival passes straight through
        exp_push(12'h010, 4'b1111, 16'h3333, "R2 R3 R10 full passthrough");
        send(3, 12'h010, 4'b1111);
        settle("R2");

        // R4 / R5: disjoint halves from two warps fill a warp
        exp_push(12'h020, 4'b1111, 16'h2211, "R4 R5 two-warp merge");
        send(1, 12'h020, 4'b0011);
        send(2, 12'h020, 4'b1100);
        settle("R5");

        // R6 / R7 / R8: overlap and PC mismatch open entries, oldest match wins
        send(4, 12'h030, 4'b0011);
        send(5, 12'h030, 4'b0010);   // overlaps: new entry (R6)
        send(6, 12'h040, 4'b0100);   // other PC: new entry (R6)
        send(7, 12'h030, 4'b0100);   // fits both same-PC entries: oldest (R7)
        exp_push(12'h030, 4'b0111, 16'h0744, "R7 R8 oldest merge, drain first");
        exp_push(12'h030, 4'b0010, 16'h0050, "R6 R8 overlap entry, drain second");
        exp_push(12'h040, 4'b0100, 16'h0600, "R6 R8 PC mismatch entry, drain third");
        do_flush();
        send(8, 12'h050, 4'b1111);   // during drain: discarded (R8)
        settle("R8 drain");
        do_flush();                   // pool must be empty now (R8)
        settle("R8 empty after drain");

        // R9: eviction of the oldest from a full array
        send(1, 12'h060, 4'b0001);
        send(2, 12'h061, 4'b0010);
        send(3, 12'h062, 4'b0100);
        send(4, 12'h063, 4'b1000);
        exp_push(12'h060, 4'b0001, 16'h0001, "R9 evict oldest");
        send(9, 12'h070, 4'b0110);
        settle("R9 evict");
        exp_push(12'h061, 4'b0010, 16'h0020, "R9 remaining order 1");
        exp_push(12'h062, 4'b0100, 16'h0300, "R9 remaining order 2");
        exp_push(12'h063, 4'b1000, 16'h4000, "R9 remaining order 3");
        exp_push(12'h070, 4'b0110, 16'h0990, "R9 new entry youngest");
        do_flush();
        settle("R9 drain");

        // R11: all-zero mask arrival is ignored
        send(2, 12'h080, 4'b0000);
        do_flush();
        settle("R11 zero mask");

        // R5: three warps complete one formed warp
        send(1, 12'h090, 4'b0001);
        send(2, 12'h090, 4'b0010);
        exp_push(12'h090, 4'b1111, 16'h3321, "R5 three-warp merge");
        send(3, 12'h090, 4'b1100);
        settle("R5 three-way");

        // R8: arrival in the same cycle as flush is dropped
        flush = 1'b1;
        send(5, 12'h0A0, 4'b1111);
        flush = 1'b0;
        settle("R8 flush-cycle arrival");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule